// File: doc/BRIEF.md
# Protected-Entry Fully Associative TLB

This block is a sixteen-entry, fully associative address translation cache. Every entry stores a valid flag, a guard flag that protects it from invalidation, a virtual page tag, a two-bit page-size code and a real page number. A combinational lookup compares one virtual address against all entries at once. It returns a hit flag, the index of the matching entry and the translated real address, all in the same cycle.

A write port loads or clears one entry chosen by index. An invalidate port accepts three kinds of request. The first is a targeted invalidate from the local core or from a remote agent. The second is an invalidate-everything command. The third is a flash-clear pulse. None of these requests can remove an entry whose guard flag is set. Such an entry goes away only when an indexed write loads it with the valid flag at 0. This keeps translations for critical code, such as interrupt handlers, resident however software or other agents flush the buffer.

Top module: `guarded_tlb`

## Requirements
- R1: After reset no entry is valid. Every lookup misses, and on a miss `lkPa` is 0 and `lkMulti` is 0.
- R2: A lookup hits when a valid entry's tag equals `lkVa[31:12]` under that entry's page mask. It reports the entry index on `lkIdx` and gives `lkPa = {rpn, lkVa[11:0]}` for 4 KiB pages in the same cycle.
- R3: Page-size code s (0..3) selects a page offset of 12+4*s bits. The lowest 4*s tag bits are excluded from the compare. Those bits of `lkPa` are taken from `lkVa`, and the remaining upper bits are taken from the entry's real page number.
- R4: A local targeted invalidate (`invEn`=1, `invAll`=0, `invSrc`=0) clears every unguarded entry whose masked tag matches `invVa`, and leaves guarded matching entries valid. A lookup in the next cycle already sees the result.
- R5: A remote targeted invalidate (`invSrc`=1) clears matching unguarded entries and skips guarded ones in the same way.
- R6: An invalidate-all (`invEn`=1, `invAll`=1) clears every unguarded entry and leaves every guarded entry valid.
- R7: A `flashInv` pulse clears every unguarded entry and leaves every guarded entry valid.
- R8: An indexed write with `wrValid`=0 clears the addressed entry even when its guard flag is set.
- R9: When an indexed write and any invalidate touch the same entry in one cycle, the entry takes the written contents.
- R10: When several entries match, `lkIdx` and `lkPa` come from the lowest-index match, and `lkMulti` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkVa | input | 32 | Lookup virtual address |
| lkHit | output | 1 | Lookup hit |
| lkIdx | output | 4 | Index of the lowest matching entry |
| lkPa | output | 32 | Translated real address (0 on miss) |
| lkMulti | output | 1 | More than one entry matched |
| wrEn | input | 1 | Indexed write strobe |
| wrIdx | input | 4 | Entry written |
| wrValid | input | 1 | Valid flag to write |
| wrProt | input | 1 | Guard flag to write |
| wrTag | input | 20 | Virtual page tag to write |
| wrSize | input | 2 | Page-size code to write |
| wrRpn | input | 20 | Real page number to write |
| invEn | input | 1 | Invalidate request strobe |
| invSrc | input | 1 | Invalidate source: 0 local, 1 remote |
| invAll | input | 1 | Invalidate-all instead of targeted |
| invVa | input | 32 | Targeted invalidate address |
| flashInv | input | 1 | Flash-clear pulse |

## Verification
Lookups are tried with exact 4 KiB matches, with addresses that differ from a tag only in bits hidden by a larger page mask, and with addresses just outside such a page. Together these separate a correct mask from one that compares too many or too few bits. Two entries sharing a tag expose the priority order and the multi-match flag. Each invalidate kind is aimed at a mix of guarded and unguarded entries, and a lookup follows at once, so a path that ignores the guard or acts a cycle late shows up. Writes issued in the same cycle as invalidates show whether the write has priority.

// File: rtl/guarded_tlb_pkg.sv
package guarded_tlb_pkg;

  // Strobes sent from the control decoder to the entry array.
  typedef struct packed {
    logic load;        // indexed write this cycle
    logic bulkKill;    // clear every unguarded entry
    logic localKill;   // targeted clear, local origin
    logic remoteKill;  // targeted clear, remote origin
  } tlbStrobes_t;

endpackage

// File: rtl/guarded_tlb_ctrl.sv
module guarded_tlb_ctrl
  import guarded_tlb_pkg::*;
(
  input  logic        wrEn,
  input  logic        invEn,
  input  logic        invSrc,
  input  logic        invAll,
  input  logic        flashInv,
  output tlbStrobes_t strobes
);

  logic targeted;

  always_comb begin
    targeted           = invEn && !invAll;
    strobes.load       = wrEn;
    strobes.bulkKill   = flashInv || (invEn && invAll);
    strobes.localKill  = targeted && !invSrc;
    strobes.remoteKill = targeted && invSrc;
  end

endmodule

// File: rtl/guarded_tlb_array.sv
module guarded_tlb_array
  import guarded_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int SIZE_W      = 2,
  parameter int SIZE_STEP   = 4,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int TAG_W      = ADDR_W - PAGE_SHIFT
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tlbStrobes_t            strobes,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic                   wrValid,
  input  logic                   wrProt,
  input  logic [TAG_W-1:0]       wrTag,
  input  logic [SIZE_W-1:0]      wrSize,
  input  logic [TAG_W-1:0]       wrRpn,
  input  logic [ADDR_W-1:0]      invVa,
  input  logic [ADDR_W-1:0]      lkVa,
  output logic                   lkHit,
  output logic [IDX_W-1:0]       lkIdx,
  output logic [ADDR_W-1:0]      lkPa,
  output logic                   lkMulti,
  output logic [NUM_ENTRIES-1:0] entValid,
  output logic [NUM_ENTRIES-1:0] entProt
);

  // Bit b of the returned mask is 1 when tag bit b takes part in the compare.
  function automatic logic [TAG_W-1:0] sizeMask(input logic [SIZE_W-1:0] code);
    logic [TAG_W-1:0] m;
    m = '0;
    for (int b = 0; b < TAG_W; b++) begin
      m[b] = (b >= SIZE_STEP * int'(code));
    end
    return m;
  endfunction

  logic [TAG_W-1:0]       lkTag;
  logic [TAG_W-1:0]       invTag;
  logic [NUM_ENTRIES-1:0] lkMatch;
  logic [NUM_ENTRIES-1:0] invMatch;
  logic [TAG_W-1:0]       maskE [NUM_ENTRIES];
  logic [TAG_W-1:0]       rpnE  [NUM_ENTRIES];

  assign lkTag  = lkVa[ADDR_W-1:PAGE_SHIFT];
  assign invTag = invVa[ADDR_W-1:PAGE_SHIFT];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic              validR;
    logic              protR;
    logic [TAG_W-1:0]  tagR;
    logic [SIZE_W-1:0] sizeR;
    logic [TAG_W-1:0]  rpnR;
    logic              selW;
    logic              killHit;

    assign selW     = strobes.load && (wrIdx == IDX_W'(i));
    assign maskE[i] = sizeMask(sizeR);
    assign rpnE[i]  = rpnR;
    assign lkMatch[i]  = validR && (((lkTag ^ tagR) & maskE[i]) == '0);
    assign invMatch[i] = (((invTag ^ tagR) & maskE[i]) == '0);
    assign killHit  = strobes.bulkKill ||
                      ((strobes.localKill || strobes.remoteKill) && invMatch[i]);
    assign entValid[i] = validR;
    assign entProt[i]  = protR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validR <= 1'b0;
        protR  <= 1'b0;
      end else if (selW) begin
        validR <= wrValid;
        protR  <= wrProt;
      end else if (validR && !protR && killHit) begin
        validR <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagR  <= '0;
        sizeR <= '0;
        rpnR  <= '0;
      end else if (selW) begin
        tagR  <= wrTag;
        sizeR <= wrSize;
        rpnR  <= wrRpn;
      end
    end
  end

  // Lowest-index priority select.
  logic [IDX_W-1:0] hitIdx;
  logic             found;

  always_comb begin
    hitIdx = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (lkMatch[i] && !found) begin
        hitIdx = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end

  logic [TAG_W-1:0] selMask;
  logic [TAG_W-1:0] selRpn;

  always_comb begin
    selMask = maskE[hitIdx];
    selRpn  = rpnE[hitIdx];
    lkHit   = found;
    lkIdx   = hitIdx;
    lkMulti = ($countones(lkMatch) > 1);
    if (found) begin
      lkPa = {(selRpn & selMask) | (lkTag & ~selMask), lkVa[PAGE_SHIFT-1:0]};
    end else begin
      lkPa = '0;
    end
  end

endmodule

// File: rtl/guarded_tlb.sv
module guarded_tlb
  import guarded_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int SIZE_W      = 2,
  parameter int SIZE_STEP   = 4,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int TAG_W      = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkVa,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [ADDR_W-1:0] lkPa,
  output logic              lkMulti,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrValid,
  input  logic              wrProt,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic [TAG_W-1:0]  wrRpn,
  input  logic              invEn,
  input  logic              invSrc,
  input  logic              invAll,
  input  logic [ADDR_W-1:0] invVa,
  input  logic              flashInv
);

  tlbStrobes_t            strobes;
  logic [NUM_ENTRIES-1:0] entValid;
  logic [NUM_ENTRIES-1:0] entProt;

  guarded_tlb_ctrl u_ctrl (
    .wrEn     (wrEn),
    .invEn    (invEn),
    .invSrc   (invSrc),
    .invAll   (invAll),
    .flashInv (flashInv),
    .strobes  (strobes)
  );

  guarded_tlb_array #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (ADDR_W),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .SIZE_W      (SIZE_W),
    .SIZE_STEP   (SIZE_STEP)
  ) u_array (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrIdx    (wrIdx),
    .wrValid  (wrValid),
    .wrProt   (wrProt),
    .wrTag    (wrTag),
    .wrSize   (wrSize),
    .wrRpn    (wrRpn),
    .invVa    (invVa),
    .lkVa     (lkVa),
    .lkHit    (lkHit),
    .lkIdx    (lkIdx),
    .lkPa     (lkPa),
    .lkMulti  (lkMulti),
    .entValid (entValid),
    .entProt  (entProt)
  );

endmodule

// File: rtl/guarded_tlb_checker.sv
module guarded_tlb_checker #(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [IDX_W-1:0]       wrIdx,
  input logic                   wrValid,
  input logic [ADDR_W-1:0]      lkVa,
  input logic                   lkHit,
  input logic [ADDR_W-1:0]      lkPa,
  input logic                   lkMulti,
  input logic [NUM_ENTRIES-1:0] entValid,
  input logic [NUM_ENTRIES-1:0] entProt
);

  assert_reset_empty_R1: assert property (@(posedge clk) !rstN |-> entValid == '0)
    else $error("entries valid during reset");

  assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkPa == '0 && !lkMulti))
    else $error("miss with nonzero address or multi flag");

  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkPa[PAGE_SHIFT-1:0] == lkVa[PAGE_SHIFT-1:0])
    else $error("page offset not passed through");

  assert_multi_has_hit_R10: assert property (@(posedge clk) disable iff (!rstN)
    lkMulti |-> lkHit)
    else $error("multi-match without hit");

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_chk
    // R4 R5 R6 R7: a guarded entry drops only by an indexed write
    assert_guard_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
      (entValid[i] && entProt[i] && !(wrEn && wrIdx == IDX_W'(i))) |=> entValid[i])
      else $error("guarded entry %0d lost", i);

    // R8 R9: the written valid flag always lands
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrIdx == IDX_W'(i)) |=> entValid[i] == $past(wrValid))
      else $error("write to entry %0d not applied", i);
  end

endmodule

bind guarded_tlb guarded_tlb_checker #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .ADDR_W      (ADDR_W),
  .PAGE_SHIFT  (PAGE_SHIFT)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrIdx    (wrIdx),
  .wrValid  (wrValid),
  .lkVa     (lkVa),
  .lkHit    (lkHit),
  .lkPa     (lkPa),
  .lkMulti  (lkMulti),
  .entValid (entValid),
  .entProt  (entProt)
);

// File: tb/guarded_tlb_test.sv
module guarded_tlb_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lkVa = '0;
  logic        lkHit;
  logic [3:0]  lkIdx;
  logic [31:0] lkPa;
  logic        lkMulti;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic        wrValid = 1'b0;
  logic        wrProt = 1'b0;
  logic [19:0] wrTag = '0;
  logic [1:0]  wrSize = '0;
  logic [19:0] wrRpn = '0;
  logic        invEn = 1'b0;
  logic        invSrc = 1'b0;
  logic        invAll = 1'b0;
  logic [31:0] invVa = '0;
  logic        flashInv = 1'b0;

  always #2 clk = ~clk;

  guarded_tlb uut (
    .clk(clk), .rstN(rstN), .lkVa(lkVa), .lkHit(lkHit), .lkIdx(lkIdx),
    .lkPa(lkPa), .lkMulti(lkMulti), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrValid(wrValid), .wrProt(wrProt), .wrTag(wrTag), .wrSize(wrSize),
    .wrRpn(wrRpn), .invEn(invEn), .invSrc(invSrc), .invAll(invAll),
    .invVa(invVa), .flashInv(flashInv)
  );

  typedef struct {
    logic        hit;
    logic [3:0]  idx;
    logic [31:0] pa;
    logic        multi;
    string       req;
  } expItem_t;

  expItem_t expQ[$];
  logic     probe = 1'b0;
  int       nChecks = 0;
  int       nFails = 0;
  bit       finished = 1'b0;

  // Monitor: compares each lookup away from the active edge.
  always @(negedge clk) begin
    if (probe && expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      nChecks++;
      if (lkHit !== e.hit || lkMulti !== e.multi || lkPa !== e.pa ||
          (e.hit && lkIdx !== e.idx)) begin
        nFails++;
        $display("FAIL %s: va=%h hit=%b idx=%0d pa=%h multi=%b expected hit=%b idx=%0d pa=%h multi=%b",
                 e.req, lkVa, lkHit, lkIdx, lkPa, lkMulti, e.hit, e.idx, e.pa, e.multi);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    wrEn = 1'b0; invEn = 1'b0; invAll = 1'b0; invSrc = 1'b0;
    flashInv = 1'b0; probe = 1'b0;
  endtask

  task automatic doWrite(input logic [3:0] idx, input logic v, input logic p,
                         input logic [19:0] tag, input logic [1:0] sz,
                         input logic [19:0] rpn);
    step();
    wrEn = 1'b1; wrIdx = idx; wrValid = v; wrProt = p;
    wrTag = tag; wrSize = sz; wrRpn = rpn;
  endtask

  task automatic doInv(input logic [31:0] va, input logic src, input logic all);
    step();
    invEn = 1'b1; invVa = va; invSrc = src; invAll = all;
  endtask

  task automatic lookup(input logic [31:0] va, input logic hit, input logic [3:0] idx,
                        input logic [31:0] pa, input logic multi, input string req);
    expItem_t e;
    step();
    lkVa = va;
    e.hit = hit; e.idx = idx; e.pa = pa; e.multi = multi; e.req = req;
    expQ.push_back(e);
    probe = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: empty after reset
    lookup(32'h0000_1000, 0, 0, 32'h0, 0, "R1");

    // R2: 4 KiB translation
    doWrite(4'd3, 1, 0, 20'h12345, 2'd0, 20'hABCDE);
    lookup(32'h1234_5678, 1, 4'd3, 32'hABCD_E678, 0, "R2");

    // R3: 1 MiB page (size 2) and 64 KiB page (size 1)
    doWrite(4'd5, 1, 0, 20'h56700, 2'd2, 20'h9AB00);
    lookup(32'h567F_EDCB, 1, 4'd5, 32'h9ABF_EDCB, 0, "R3");
    lookup(32'h5680_0000, 0, 0, 32'h0, 0, "R3");
    doWrite(4'd7, 1, 0, 20'h22220, 2'd1, 20'h33330);
    lookup(32'h2222_ABCD, 1, 4'd7, 32'h3333_ABCD, 0, "R3");

    // R10: two entries with one tag
    doWrite(4'd12, 1, 0, 20'h12345, 2'd0, 20'h11111);
    lookup(32'h1234_5000, 1, 4'd3, 32'hABCD_E000, 1, "R10");

    // R4: local targeted invalidate, guarded e10 and unguarded e11
    doWrite(4'd10, 1, 1, 20'h44444, 2'd0, 20'h55555);
    doWrite(4'd11, 1, 0, 20'h44444, 2'd0, 20'h66666);
    lookup(32'h4444_4000, 1, 4'd10, 32'h5555_5000, 1, "R4");
    doInv(32'h4444_4000, 0, 0);
    lookup(32'h4444_4000, 1, 4'd10, 32'h5555_5000, 0, "R4");

    // R5: remote targeted invalidate removes both unguarded e3 and e12
    doInv(32'h1234_5000, 1, 0);
    lookup(32'h1234_5000, 0, 0, 32'h0, 0, "R5");
    doWrite(4'd6, 1, 1, 20'hBBBBB, 2'd0, 20'h0CCCC);
    doInv(32'hBBBB_B000, 1, 0);
    lookup(32'hBBBB_B010, 1, 4'd6, 32'h0CCC_C010, 0, "R5");

    // R6: invalidate-all
    doWrite(4'd1, 1, 1, 20'h77777, 2'd0, 20'h01234);
    doWrite(4'd2, 1, 0, 20'h88888, 2'd0, 20'h0AAAA);
    doInv(32'h0, 0, 1);
    lookup(32'h8888_8000, 0, 0, 32'h0, 0, "R6");
    lookup(32'h7777_7000, 1, 4'd1, 32'h0123_4000, 0, "R6");
    lookup(32'h567F_EDCB, 0, 0, 32'h0, 0, "R6");
    lookup(32'h4444_4123, 1, 4'd10, 32'h5555_5123, 0, "R6");

    // R7: flash clear
    doWrite(4'd2, 1, 0, 20'h88888, 2'd0, 20'h0AAAA);
    step();
    flashInv = 1'b1;
    lookup(32'h8888_8000, 0, 0, 32'h0, 0, "R7");
    lookup(32'h7777_7000, 1, 4'd1, 32'h0123_4000, 0, "R7");

    // R8: clearing write removes a guarded entry
    doWrite(4'd1, 0, 1, 20'h77777, 2'd0, 20'h01234);
    lookup(32'h7777_7000, 0, 0, 32'h0, 0, "R8");

    // R9: write and flash in one cycle, then write and targeted invalidate
    doWrite(4'd4, 1, 0, 20'h99999, 2'd0, 20'h02222);
    flashInv = 1'b1;
    lookup(32'h9999_9ABC, 1, 4'd4, 32'h0222_2ABC, 0, "R9");
    doWrite(4'd4, 1, 0, 20'h99999, 2'd0, 20'h03333);
    invEn = 1'b1; invVa = 32'h9999_9000; invSrc = 1'b0; invAll = 1'b0;
    lookup(32'h9999_9ABC, 1, 4'd4, 32'h0333_3ABC, 0, "R9");

    step();
    step();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule